// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block sends one asynchronous character on a single serial line each time it is given a load strobe. Its framing and bit rate come from static configuration inputs of the kind a serial controller keeps in registers. A 16-bit time constant and a two-bit clock-mode field set the rate. A two-bit length code sets the character size. There is a parity enable, a parity sense bit and a two-bit stop field. A transmit-enable bit gates whether loads are accepted at all.

The bit-rate chain first halves the system clock. It then divides by the time constant plus two, and then by a clock-mode factor of 1, 16, 32 or 64. One bit on the line therefore lasts 2·(TC+2)·factor clock cycles. The line idles high. A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. An all-sent flag is low while a frame is on the line. Every configuration value is captured when a character is accepted, so a new setting applies from the next character.

Top module: `cfg_serial_tx`

## Requirements
- R1: After reset the line output `txd` is 1 and `all_sent` is 1.
- R2: Each bit on the line lasts exactly 2·(tc_value+2)·F clock cycles. F is 1, 16, 32 or 64 for `clk_mode` codes 00, 01, 10 and 11.
- R3: `len_code` selects the character length: 00 gives 5 bits, 01 gives 7, 10 gives 6 and 11 gives 8. Data is sent least significant bit first, and bits of `load_data` above the selected length are not sent.
- R4: A frame starts with one low start bit in the cycle after the accepting clock edge. The data bits follow, then the parity bit if enabled, then the stop bits at 1. The line returns to and stays at 1 afterwards.
- R5: When `par_en` is 1, a parity bit is sent after the data. With `par_even` at 1, the count of ones over the sent data bits plus the parity bit is even. With `par_even` at 0, that count is odd. When `par_en` is 0 no parity bit is sent.
- R6: `stop_code` 11 sends two stop bits. Any other value sends one stop bit.
- R7: A load strobe while `tx_enable` is 0 is ignored: `txd` stays 1 and `all_sent` stays 1.
- R8: `all_sent` falls on the clock edge that accepts a load. It rises exactly frame_bits·bit_time cycles later, at the end of the last stop bit.
- R9: A load strobe while `all_sent` is 0 is ignored, and the frame in progress is sent unchanged.
- R10: Changes to `tc_value`, `clk_mode`, `len_code`, `par_en`, `par_even` or `stop_code` during a frame do not affect that frame. They take effect at the next accepted load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tc_value | input | TC_W | Bit-rate time constant |
| clk_mode | input | 2 | Rate factor select (1/16/32/64) |
| len_code | input | 2 | Character length code |
| par_en | input | 1 | Parity enable |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| stop_code | input | 2 | Stop-bit field; 11 = two stop bits |
| tx_enable | input | 1 | Transmit enable; loads are ignored when 0 |
| load | input | 1 | One-cycle strobe that starts a character |
| load_data | input | CHAR_W | Character to send |
| txd | output | 1 | Serial line, idles high |
| all_sent | output | 1 | 1 when no frame is on the line |

## Verification
The bench sweeps every length code together with every parity setting and both stop-bit counts. It also sweeps small time constants and all four clock-mode factors. It compares the line against an arithmetically computed waveform in every cycle of each frame.

The non-monotonic length order is a likely failure point. A design that decoded it as 5, 6, 7, 8 would send one bit too many or too few for codes 01 and 10, and the stop bit would arrive early or late. A parity bit with the wrong sense, or computed over unsent high bits, shows up as one inverted cycle span. A divider built as (TC+1), or one missing the fixed halving, stretches or shrinks every bit and moves the rise of `all_sent`.

Two further cases are targeted. A load arriving mid-frame, and configuration changed mid-frame, must both leave the frame untouched. A design that re-sampled its inputs would visibly reshape the frame.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int TC_W_DEF  = 16;
    localparam int CHAR_MAX  = 8;
    localparam int FAC_W     = 6;

    typedef enum logic [1:0] {
        CM_X1  = 2'b00,
        CM_X16 = 2'b01,
        CM_X32 = 2'b10,
        CM_X64 = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        LEN5 = 2'b00,
        LEN7 = 2'b01,
        LEN6 = 2'b10,
        LEN8 = 2'b11
    } len_code_e;

    typedef struct packed {
        len_code_e len;
        logic      par_en;
        logic      par_even;
        logic      two_stop;
    } frame_fmt_t;

    // number of data bits for a length code (order is 5,7,6,8)
    function automatic logic [3:0] char_bits(len_code_e c);
        logic [3:0] n;
        unique case (c)
            LEN5:    n = 4'd5;
            LEN7:    n = 4'd7;
            LEN6:    n = 4'd6;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

    // terminal count of the mode prescaler (factor - 1)
    function automatic logic [FAC_W-1:0] fac_last(clk_mode_e m);
        logic [FAC_W-1:0] v;
        unique case (m)
            CM_X1:   v = FAC_W'(0);
            CM_X16:  v = FAC_W'(15);
            CM_X32:  v = FAC_W'(31);
            default: v = FAC_W'(63);
        endcase
        return v;
    endfunction

    // mask keeping only the data bits that are sent
    function automatic logic [CHAR_MAX-1:0] char_mask(len_code_e c);
        logic [CHAR_MAX:0] one_hot;
        one_hot = (CHAR_MAX+1)'(1) << char_bits(c);
        return CHAR_MAX'(one_hot - (CHAR_MAX+1)'(1));
    endfunction

    function automatic logic parity_of(logic [CHAR_MAX-1:0] d, logic even);
        return even ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/stx_baud_gen.sv
module stx_baud_gen
    import stx_pkg::*;
#(
    parameter int TC_W = TC_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [TC_W-1:0]  tc_in,
    input  logic [FAC_W-1:0] fac_last_in,
    output logic             bit_tick
);
    localparam int TCC_W = TC_W + 1;

    logic             half_q;
    logic [TCC_W-1:0] tc_cnt_q;
    logic [TCC_W-1:0] tc_end_q;
    logic [FAC_W-1:0] fac_cnt_q;
    logic [FAC_W-1:0] fac_end_q;
    logic             tc_wrap;

    assign tc_wrap  = half_q && (tc_cnt_q == tc_end_q);
    assign bit_tick = run && tc_wrap && (fac_cnt_q == fac_end_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q    <= 1'b0;
            tc_cnt_q  <= '0;
            tc_end_q  <= TCC_W'(1);
            fac_cnt_q <= '0;
            fac_end_q <= '0;
        end else if (restart) begin
            half_q    <= 1'b0;
            tc_cnt_q  <= '0;
            tc_end_q  <= TCC_W'(tc_in) + TCC_W'(1);
            fac_cnt_q <= '0;
            fac_end_q <= fac_last_in;
        end else if (run) begin
            half_q <= ~half_q;
            if (half_q) begin
                if (tc_wrap) begin
                    tc_cnt_q <= '0;
                    if (fac_cnt_q == fac_end_q) begin
                        fac_cnt_q <= '0;
                    end else begin
                        fac_cnt_q <= fac_cnt_q + FAC_W'(1);
                    end
                end else begin
                    tc_cnt_q <= tc_cnt_q + TCC_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/stx_frame_build.sv
module stx_frame_build
    import stx_pkg::*;
#(
    parameter int CHAR_W  = CHAR_MAX,
    parameter int FRAME_W = CHAR_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  frame_fmt_t          fmt,
    input  logic [CHAR_W-1:0]   data,
    output logic [FRAME_W-1:0]  bits,
    output logic [CNT_W-1:0]    nbits
);
    logic [3:0]        nb;
    logic [CHAR_W-1:0] masked;
    logic              par;

    assign nb     = char_bits(fmt.len);
    assign masked = data & CHAR_W'(char_mask(fmt.len));
    assign par    = parity_of(CHAR_MAX'(masked), fmt.par_even);
    assign nbits  = CNT_W'(2) + CNT_W'(nb) + CNT_W'(fmt.par_en) + CNT_W'(fmt.two_stop);

    always_comb begin
        bits    = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < int'(nb)) begin
                bits[1+i] = masked[i];
            end
        end
        if (fmt.par_en) begin
            bits[int'(nb) + 1] = par;
        end
    end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
    parameter int FRAME_W = 12,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [CNT_W-1:0]   nbits_in,
    input  logic               bit_tick,
    output logic               line,
    output logic               busy
);
    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   left_q;

    assign line = frame_q[0];
    assign busy = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '1;
            left_q  <= '0;
        end else if (take) begin
            frame_q <= frame_in;
            left_q  <= nbits_in;
        end else if (bit_tick && busy) begin
            frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            left_q  <= left_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/cfg_serial_tx.sv
module cfg_serial_tx
    import stx_pkg::*;
#(
    parameter int TC_W   = TC_W_DEF,
    parameter int CHAR_W = CHAR_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TC_W-1:0]   tc_value,
    input  logic [1:0]        clk_mode,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_even,
    input  logic [1:0]        stop_code,
    input  logic              tx_enable,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    output logic              txd,
    output logic              all_sent
);
    localparam int FRAME_W = CHAR_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    frame_fmt_t         fmt;
    logic [FRAME_W-1:0] frame_bits;
    logic [CNT_W-1:0]   frame_len;
    logic               busy;
    logic               accept;
    logic               tick;

    assign fmt.len      = len_code_e'(len_code);
    assign fmt.par_en   = par_en;
    assign fmt.par_even = par_even;
    assign fmt.two_stop = (stop_code == 2'b11);

    assign accept   = load && tx_enable && !busy;
    assign all_sent = !busy;

    stx_frame_build #(
        .CHAR_W (CHAR_W),
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_build (
        .fmt  (fmt),
        .data (load_data),
        .bits (frame_bits),
        .nbits(frame_len)
    );

    stx_baud_gen #(
        .TC_W(TC_W)
    ) u_rate (
        .clk        (clk),
        .rst        (rst),
        .restart    (accept),
        .run        (busy),
        .tc_in      (tc_value),
        .fac_last_in(fac_last(clk_mode_e'(clk_mode))),
        .bit_tick   (tick)
    );

    stx_shifter #(
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .take    (accept),
        .frame_in(frame_bits),
        .nbits_in(frame_len),
        .bit_tick(tick),
        .line    (txd),
        .busy    (busy)
    );

endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
    parameter int TC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [TC_W-1:0] tc_value,
    input logic [1:0]      clk_mode,
    input logic            tx_enable,
    input logic            load,
    input logic            txd,
    input logic            all_sent
);
    logic [31:0] phase_q;
    logic [31:0] span_q;
    logic [31:0] span_new;
    logic [31:0] fac;
    logic        acc;

    assign acc = load && tx_enable && all_sent;

    always_comb begin
        case (clk_mode)
            2'b00:   fac = 32'd1;
            2'b01:   fac = 32'd16;
            2'b10:   fac = 32'd32;
            default: fac = 32'd64;
        endcase
        span_new = 32'd2 * (32'(tc_value) + 32'd2) * fac;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            span_q  <= 32'd4;
        end else if (acc) begin
            phase_q <= '0;
            span_q  <= span_new;
        end else if (!all_sent) begin
            phase_q <= (phase_q == span_q - 32'd1) ? 32'd0 : phase_q + 32'd1;
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        all_sent |-> txd); // R4

    AST_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        acc |=> (!txd && !all_sent)); // R8

    AST_DISABLED_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (load && !tx_enable && all_sent) |=> (all_sent && txd)); // R7

    AST_EDGE_ON_BIT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (txd != $past(txd)) |-> (phase_q == 32'd0)); // R2

    AST_DONE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(all_sent) |-> (phase_q == 32'd0 && txd)); // R8

    AST_BUSY_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (rst)
        $fell(all_sent) |-> $past(load && tx_enable)); // R9

endmodule

bind cfg_serial_tx stx_checker #(.TC_W(TC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tc_value (tc_value),
    .clk_mode (clk_mode),
    .tx_enable(tx_enable),
    .load     (load),
    .txd      (txd),
    .all_sent (all_sent)
);

// File: tb/cfg_serial_tx_test.sv
`timescale 1ns/1ps
module cfg_serial_tx_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tc_value = '0;
    logic [1:0]  clk_mode = '0;
    logic [1:0]  len_code = 2'b11;
    logic        par_en = 1'b0;
    logic        par_even = 1'b0;
    logic [1:0]  stop_code = 2'b01;
    logic        tx_enable = 1'b0;
    logic        load = 1'b0;
    logic [7:0]  load_data = '0;
    logic        txd;
    logic        all_sent;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    cfg_serial_tx uut (
        .clk(clk), .rst(rst), .tc_value(tc_value), .clk_mode(clk_mode),
        .len_code(len_code), .par_en(par_en), .par_even(par_even),
        .stop_code(stop_code), .tx_enable(tx_enable), .load(load),
        .load_data(load_data), .txd(txd), .all_sent(all_sent)
    );

    function automatic int fac_of(logic [1:0] m);
        case (m)
            2'b00:   return 1;
            2'b01:   return 16;
            2'b10:   return 32;
            default: return 64;
        endcase
    endfunction

    function automatic int len_of(logic [1:0] c);
        case (c)
            2'b00:   return 5;
            2'b01:   return 7;
            2'b10:   return 6;
            default: return 8;
        endcase
    endfunction

    task automatic report(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // mode 0: plain frame, 1: config changed mid-frame, 2: load while busy
    task automatic send(input logic [7:0] d, input logic [15:0] tc, input logic [1:0] md,
                        input logic [1:0] lc, input logic pe, input logic pv,
                        input logic [1:0] sc, input int mode, input string req);
        logic [15:0] e;
        int nd, ones, nf, bt, k_bad, a_bad, e_bad;
        bit ok;
        nd = len_of(lc);
        bt = 2 * (int'(tc) + 2) * fac_of(md);
        e = '1;
        e[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            e[1+i] = d[i];
            ones += int'(d[i]);
        end
        if (pe) e[1+nd] = pv ? logic'(ones % 2) : logic'(1 - ones % 2);
        nf = 2 + nd + int'(pe) + ((sc == 2'b11) ? 1 : 0);

        @(negedge clk);
        tc_value = tc; clk_mode = md; len_code = lc; par_en = pe;
        par_even = pv; stop_code = sc; load_data = d; tx_enable = 1'b1; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        ok = 1'b1; k_bad = -1; a_bad = 0; e_bad = 0;
        for (int k = 0; k <= nf * bt + 1; k++) begin
            logic et, ea;
            et = (k < nf * bt) ? e[k / bt] : 1'b1;
            ea = (k >= nf * bt);
            if (ok && (txd !== et || all_sent !== ea)) begin
                ok = 1'b0; k_bad = k;
                a_bad = {30'd0, all_sent, txd}; e_bad = {30'd0, ea, et};
            end
            if (mode == 1 && k == bt + 1) begin
                tc_value = tc + 16'd3; clk_mode = md ^ 2'b01; len_code = ~lc;
                par_en = ~pe; par_even = ~pv; stop_code = (sc == 2'b11) ? 2'b01 : 2'b11;
            end
            if (mode == 2 && k == bt + 1) begin
                load = 1'b1; load_data = ~d;
            end
            if (mode == 2 && k == bt + 2) load = 1'b0;
            @(negedge clk);
        end
        report(ok, req, $sformatf("frame d=%02h tc=%0d md=%0d lc=%0d pe=%0d pv=%0d sc=%0d cycle=%0d {all_sent,txd}",
               d, tc, md, lc, pe, pv, sc, k_bad), a_bad, e_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        report(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        report(all_sent === 1'b1, "R1", "all_sent after reset", int'(all_sent), 1);

        // R7: load with transmit disabled
        tx_enable = 1'b0; load_data = 8'h00; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        begin
            bit ok7 = 1'b1;
            for (int k = 0; k < 40; k++) begin
                if (txd !== 1'b1 || all_sent !== 1'b1) ok7 = 1'b0;
                @(negedge clk);
            end
            report(ok7, "R7", "line idle after disabled load", int'(ok7), 1);
        end

        // R3 R4 R5 R6 R8: all lengths, parity settings and stop counts
        for (int lc = 0; lc < 4; lc++)
            for (int pm = 0; pm < 3; pm++)
                for (int s = 0; s < 2; s++) begin
                    send(8'hA5, 16'd0, 2'b00, 2'(lc), pm != 0, pm == 2,
                         s ? 2'b11 : 2'b01, 0, "R3/R4/R5/R6/R8");
                    send(8'h3C, 16'd0, 2'b00, 2'(lc), pm != 0, pm == 2,
                         s ? 2'b11 : 2'b10, 0, "R3/R4/R5/R6/R8");
                end

        // R2: time-constant sweep and every mode factor
        for (int tc = 0; tc < 6; tc++)
            send(8'h96, 16'(tc), 2'b00, 2'b11, 1'b1, 1'b0, 2'b01, 0, "R2");
        for (int md = 1; md < 4; md++)
            send(8'h4B, 16'd1, 2'(md), 2'b10, 1'b0, 1'b0, 2'b01, 0, "R2");

        // R10: configuration changes mid-frame
        send(8'hC3, 16'd2, 2'b00, 2'b01, 1'b1, 1'b1, 2'b01, 1, "R10");
        send(8'h5A, 16'd0, 2'b00, 2'b11, 1'b0, 1'b0, 2'b11, 1, "R10");

        // R9: load while busy
        send(8'hF0, 16'd1, 2'b00, 2'b11, 1'b1, 1'b0, 2'b01, 2, "R9");
        send(8'h81, 16'd0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b11, 2, "R9");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule